// File: doc/BRIEF.md
# Serial Port Control and Interrupt Register File

This block is the software-visible register file of a serial port peripheral. It decodes a simple 32-bit, word-aligned register access port. It keeps four sticky interrupt causes with their enables and drives four level interrupt lines. It also stores the configuration words that the transmit and receive datapath consume. The datapath sits outside this block. It reports events as single-cycle pulses, offers a received byte and a set of status flags, and takes back a push strobe with a byte to send, a pop strobe and two flush strobes.

Software clears interrupt causes by writing ones to the state register. It can raise any cause on purpose through a separate test register. Each interrupt line is the AND of its cause bit and its enable bit, so it follows any change to either one at the first clock edge after that change. Reads return data one cycle after the request, flagged by a valid strobe. Offsets that are not mapped read as zero and ignore writes.

Top module: `sercom_csr`

## Requirements
- R1: After reset, every stored register is zero, all four interrupt lines are low, all strobes are low and `reg_rdata` is zero.
- R2: A write to offset 0x00 clears each cause bit whose write-data bit is 1 and leaves the other cause bits unchanged. Cause bits are: TX watermark at bit 0, RX watermark at bit 1, TX empty at bit 2, RX overflow at bit 3.
- R3: A write to offset 0x08 ORs write-data bits [3:0] into the cause bits. Offset 0x08 reads as zero.
- R4: Offset 0x04 holds the enable bits in [3:0] and reads them back. `irq[i]` is high exactly when cause bit i and enable bit i are both set, from the edge that stores a write to 0x00, 0x04 or 0x08 onward.
- R5: A pulse on `evt_set[i]` sets cause bit i, and the bit stays set until software clears it. When a pulse and a clearing write to the same bit fall in the same cycle, the bit ends up set.
- R6: Offset 0x0C stores control bits 0, 1, 2, 4, 5, 6, 7, [9:8] and [31:16] (mask 0xFFFF03F7). Other bits are stored as zero. The stored word reads back and drives `cfg_ctrl`.
- R7: Offset 0x10 reads the status flags: `st_flags[0..2]` at bits 0..2, `st_flags[3]` at bit 4, `st_flags[4]` at bit 5, and zero elsewhere. Writes to it change nothing.
- R8: A read of offset 0x14 returns `rx_byte` in the low bits and raises `rx_pop` for one cycle, aligned with `reg_rvalid`. Writes to 0x14 change nothing and raise no strobe.
- R9: A write to offset 0x18 raises `tx_push` for one cycle after the write edge, with `tx_byte` equal to write-data [7:0]. Offset 0x18 reads as zero.
- R10: A write to offset 0x1C raises `rx_flush` for one cycle if bit 0 is set and `tx_flush` for one cycle if bit 1 is set. It stores [4:2] on `rx_lvl` and [6:5] on `tx_lvl`. A read returns the stored fields with bits 0 and 1 as zero.
- R11: A write to an unmapped or misaligned address has no effect, and a read from one returns zero.
- R12: `reg_rvalid` is high in the cycle after each cycle with `reg_rd` high, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write request |
| reg_rd | input | 1 | Read request |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid |
| evt_set | input | 4 | Event pulses from the datapath, one per cause |
| st_flags | input | 5 | TX full, RX full, TX empty, RX idle, RX empty |
| rx_byte | input | DATA_W | Received byte offered by the datapath |
| irq | output | 4 | Level interrupt lines |
| cfg_ctrl | output | 32 | Stored control word |
| rx_lvl | output | 3 | Receive interrupt level field |
| tx_lvl | output | 2 | Transmit interrupt level field |
| rx_flush | output | 1 | One-cycle receive queue flush |
| tx_flush | output | 1 | One-cycle transmit queue flush |
| tx_push | output | 1 | One-cycle transmit byte strobe |
| tx_byte | output | DATA_W | Byte to transmit |
| rx_pop | output | 1 | One-cycle receive byte consumed strobe |

## Verification
A hardware event pulse and a software write-one-to-clear can hit the same cause bit in the same cycle, and the bit must come out set. The bench drives `evt_set` and a clearing write to offset 0x00 in the same cycle. The cleared bits and the pulsed bit overlap only in part. The bench then reads the state through the register port and expects the pulsed bit set, the other cleared bits gone and the untouched bits kept. It also checks that the interrupt lines reflect that result one edge later.

// File: rtl/sercom_pkg.sv
// Package: shared constants for the serial port register file.
// Assumes 32-bit word-aligned registers and an index decoded from address bits [.:2].
package sercom_pkg;
    localparam int NUM_IRQ = 4;
    localparam int NUM_REG = 8;
    localparam int WORD_W  = 32;

    // Word index of each register; software depends on these offsets.
    localparam int RG_ISTATE = 0;
    localparam int RG_IEN    = 1;
    localparam int RG_ITEST  = 2;
    localparam int RG_CTRL   = 3;
    localparam int RG_STAT   = 4;
    localparam int RG_RXD    = 5;
    localparam int RG_TXD    = 6;
    localparam int RG_FCTL   = 7;

    // Control bits that are implemented; the rest are stored as zero.
    localparam logic [WORD_W-1:0] CTRL_MASK = 32'hFFFF_03F7;
endpackage

// File: rtl/sercom_irq.sv
// Module: sticky interrupt causes, enables and level outputs.
// Assumes at most one of wr_clr / wr_en / wr_test per cycle (one address per access).
// Hardware set has priority over a software clear of the same bit.
module sercom_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_clr,
    input  logic         wr_en,
    input  logic         wr_test,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] evt_set,
    output logic [N-1:0] intr_state,
    output logic [N-1:0] intr_enable,
    output logic [N-1:0] irq
);
    // One flop per cause bit: set by event or test, cleared by write-1.
    for (genvar i = 0; i < N; i++) begin : g_cause
        logic clr_i;
        logic set_i;
        assign clr_i = wr_clr & wdata[i];
        assign set_i = evt_set[i] | (wr_test & wdata[i]);

        // Sticky cause update with set-wins priority.
        always_ff @(posedge clk) begin
            if (!rst_n)     intr_state[i] <= 1'b0;
            else if (set_i) intr_state[i] <= 1'b1;
            else if (clr_i) intr_state[i] <= 1'b0;
        end
    end

    // Enable register, plain load.
    always_ff @(posedge clk) begin
        if (!rst_n)     intr_enable <= '0;
        else if (wr_en) intr_enable <= wdata;
    end

    // Level outputs follow stored cause and enable.
    assign irq = intr_state & intr_enable;
endmodule

// File: rtl/sercom_cfg.sv
// Module: control and FIFO-control storage plus one-cycle datapath strobes.
// Assumes decoded, mutually exclusive write selects.
module sercom_cfg
    import sercom_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_fctl,
    input  logic              wr_txd,
    input  logic              rd_rxd,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] ctrl_q,
    output logic [2:0]        rx_lvl,
    output logic [1:0]        tx_lvl,
    output logic              rx_flush,
    output logic              tx_flush,
    output logic              tx_push,
    output logic [DATA_W-1:0] tx_byte,
    output logic              rx_pop
);
    // Control word keeps only implemented bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= wdata & CTRL_MASK;
    end

    // Interrupt level fields of the FIFO control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_lvl <= '0;
            tx_lvl <= '0;
        end else if (wr_fctl) begin
            rx_lvl <= wdata[4:2];
            tx_lvl <= wdata[6:5];
        end
    end

    // Self-clearing strobes toward the datapath.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_flush <= 1'b0;
            tx_flush <= 1'b0;
            tx_push  <= 1'b0;
            rx_pop   <= 1'b0;
        end else begin
            rx_flush <= wr_fctl & wdata[0];
            tx_flush <= wr_fctl & wdata[1];
            tx_push  <= wr_txd;
            rx_pop   <= rd_rxd;
        end
    end

    // Transmit byte holds its last written value.
    always_ff @(posedge clk) begin
        if (!rst_n)      tx_byte <= '0;
        else if (wr_txd) tx_byte <= wdata[DATA_W-1:0];
    end
endmodule

// File: rtl/sercom_rdmux.sv
// Module: registered read multiplexer over one-hot selects.
// Assumes rsel is one-hot or zero; zero select returns zero.
module sercom_rdmux
    import sercom_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd,
    input  logic [NUM_REG-1:0]              rsel,
    input  logic [NUM_REG-1:0][WORD_W-1:0]  words,
    output logic [WORD_W-1:0]               rdata,
    output logic                            rvalid
);
    logic [WORD_W-1:0] mux;

    // AND-OR select; unmapped addresses give all-zero.
    always_comb begin
        mux = '0;
        for (int k = 0; k < NUM_REG; k++) begin
            mux |= words[k] & {WORD_W{rsel[k]}};
        end
    end

    // Capture the read result one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd;
            rdata  <= rd ? mux : '0;
        end
    end
endmodule

// File: rtl/sercom_csr.sv
// Module: top of the serial port register file.
// Decodes the access port, instances cause/enable logic, configuration storage
// and the read path. Assumes byte addresses; only word-aligned ones are mapped.
module sercom_csr
    import sercom_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_rvalid,
    input  logic [3:0]        evt_set,
    input  logic [4:0]        st_flags,
    input  logic [DATA_W-1:0] rx_byte,
    output logic [3:0]        irq,
    output logic [31:0]       cfg_ctrl,
    output logic [2:0]        rx_lvl,
    output logic [1:0]        tx_lvl,
    output logic              rx_flush,
    output logic              tx_flush,
    output logic              tx_push,
    output logic [DATA_W-1:0] tx_byte,
    output logic              rx_pop
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]                  word_idx;
    logic                              aligned;
    logic [NUM_REG-1:0]                hit;
    logic [NUM_REG-1:0]                wsel;
    logic [NUM_REG-1:0]                rsel;
    logic [NUM_IRQ-1:0]                intr_state;
    logic [NUM_IRQ-1:0]                intr_enable;
    logic [NUM_REG-1:0][WORD_W-1:0]    words;

    assign word_idx = reg_addr[ADDR_W-1:2];
    assign aligned  = (reg_addr[1:0] == 2'b00);

    // One-hot address decode, one comparator per register.
    for (genvar k = 0; k < NUM_REG; k++) begin : g_dec
        assign hit[k] = aligned && (word_idx == IDX_W'(k));
    end

    assign wsel = hit & {NUM_REG{reg_wr}};
    assign rsel = hit & {NUM_REG{reg_rd}};

    sercom_irq #(.N(NUM_IRQ)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_clr      (wsel[RG_ISTATE]),
        .wr_en       (wsel[RG_IEN]),
        .wr_test     (wsel[RG_ITEST]),
        .wdata       (reg_wdata[NUM_IRQ-1:0]),
        .evt_set     (evt_set),
        .intr_state  (intr_state),
        .intr_enable (intr_enable),
        .irq         (irq)
    );

    sercom_cfg #(.DATA_W(DATA_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wsel[RG_CTRL]),
        .wr_fctl  (wsel[RG_FCTL]),
        .wr_txd   (wsel[RG_TXD]),
        .rd_rxd   (rsel[RG_RXD]),
        .wdata    (reg_wdata),
        .ctrl_q   (cfg_ctrl),
        .rx_lvl   (rx_lvl),
        .tx_lvl   (tx_lvl),
        .rx_flush (rx_flush),
        .tx_flush (tx_flush),
        .tx_push  (tx_push),
        .tx_byte  (tx_byte),
        .rx_pop   (rx_pop)
    );

    // Read-side view of every register; write-only ones read as zero.
    always_comb begin
        words            = '0;
        words[RG_ISTATE] = WORD_W'(intr_state);
        words[RG_IEN]    = WORD_W'(intr_enable);
        words[RG_CTRL]   = cfg_ctrl;
        words[RG_STAT]   = WORD_W'({st_flags[4:3], 1'b0, st_flags[2:0]});
        words[RG_RXD]    = WORD_W'(rx_byte);
        words[RG_FCTL]   = WORD_W'({tx_lvl, rx_lvl, 2'b00});
    end

    sercom_rdmux u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (reg_rd),
        .rsel   (rsel),
        .words  (words),
        .rdata  (reg_rdata),
        .rvalid (reg_rvalid)
    );
endmodule

// File: rtl/sercom_csr_chk.sv
// Module: property checker for sercom_csr, attached by bind.
// Assumes synchronous active-low reset; checks port and cause-state behaviour.
module sercom_csr_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              reg_rvalid,
    input logic [3:0]        evt_set,
    input logic [3:0]        intr_state,
    input logic              tx_push,
    input logic              rx_pop
);
    AST_RVALID_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid); // R12
    AST_RVALID_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rvalid |-> $past(reg_rd)); // R12
    AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_set) |=> ((intr_state & $past(evt_set)) == $past(evt_set))); // R5
    AST_TEST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(8'h08)) |=>
        ((intr_state & $past(reg_wdata[3:0])) == $past(reg_wdata[3:0]))); // R3
    AST_W1C_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(8'h00) && reg_wdata[3:0] == 4'hF && evt_set == 4'h0)
        |=> (intr_state == 4'h0)); // R2
    AST_PUSH_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> $past(reg_wr && reg_addr == ADDR_W'(8'h18))); // R9
    AST_POP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> $past(reg_rd && reg_addr == ADDR_W'(8'h14))); // R8
endmodule

bind sercom_csr sercom_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rvalid (reg_rvalid),
    .evt_set    (evt_set),
    .intr_state (intr_state),
    .tx_push    (tx_push),
    .rx_pop     (rx_pop)
);

// File: tb/sim_sercom_csr.sv
// Bench: read tasks queue expected words; a negedge monitor pops and compares.
module sim_sercom_csr;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              reg_rvalid;
    logic [3:0]        evt_set = '0;
    logic [4:0]        st_flags = '0;
    logic [DATA_W-1:0] rx_byte = '0;
    logic [3:0]        irq;
    logic [31:0]       cfg_ctrl;
    logic [2:0]        rx_lvl;
    logic [1:0]        tx_lvl;
    logic              rx_flush, tx_flush, tx_push, rx_pop;
    logic [DATA_W-1:0] tx_byte;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;
    rd_item_t exp_q[$];

    // Bench-side model of the software-visible state.
    logic [3:0] m_state = '0;
    logic [3:0] m_en = '0;

    always #2 clk = ~clk;

    sercom_csr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .evt_set(evt_set), .st_flags(st_flags),
        .rx_byte(rx_byte), .irq(irq), .cfg_ctrl(cfg_ctrl), .rx_lvl(rx_lvl),
        .tx_lvl(tx_lvl), .rx_flush(rx_flush), .tx_flush(tx_flush),
        .tx_push(tx_push), .tx_byte(tx_byte), .rx_pop(rx_pop)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One write cycle; returns at the negedge after the storing edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] ev = 4'h0);
        reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d; evt_set = ev;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; evt_set = 4'h0;
    endtask

    // One read cycle; the expected word is queued for the monitor.
    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        rd_item_t it;
        it.exp = exp; it.tag = tag;
        exp_q.push_back(it);
        reg_rd = 1'b1; reg_addr = ADDR_W'(a);
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Monitor: compares every returned word with the queue head.
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R12 actual=unexpected-rvalid expected=none");
            end else begin
                rd_item_t it;
                it = exp_q.pop_front();
                chk(it.tag, reg_rdata, it.exp);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during and right after reset.
        chk("R1 irq", 32'(irq), 0);
        chk("R1 strobes", 32'({rx_flush, tx_flush, tx_push, rx_pop}), 0);
        chk("R1 rdata", reg_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cfg_ctrl", cfg_ctrl, 0);
        rd(8'h00, 0, "R1 istate");
        rd(8'h04, 0, "R1 ienable");
        rd(8'h1C, 0, "R1 fctl");

        // R4: enables read back, nothing pending yet.
        wr(8'h04, 32'hFFFF_FFFF); m_en = 4'hF;
        chk("R4 irq idle", 32'(irq), 0);
        rd(8'h04, 32'h0000_000F, "R4 ienable");

        // R3: test register forces causes, reads zero.
        wr(8'h08, 32'h0000_0005); m_state |= 4'h5;
        chk("R3 irq after test", 32'(irq), 32'(m_state & m_en));
        rd(8'h08, 0, "R3 itest reads zero");

        // R2: write-one clears only the selected cause.
        wr(8'h00, 32'h0000_0001); m_state &= ~4'h1;
        chk("R2 irq after clear", 32'(irq), 32'h4);
        wr(8'h00, 32'h0000_0000);
        chk("R2 zero write keeps", 32'(irq), 32'h4);

        // R4: enable gating.
        wr(8'h04, 32'h3); m_en = 4'h3;
        chk("R4 gated off", 32'(irq), 0);
        wr(8'h04, 32'hF); m_en = 4'hF;
        chk("R4 gated on", 32'(irq), 32'h4);

        // R5: event pulse sets and sticks.
        evt_set = 4'h8;
        @(posedge clk); @(negedge clk);
        evt_set = 4'h0; m_state |= 4'h8;
        chk("R5 event sets", 32'(irq), 32'hC);
        repeat (3) @(negedge clk);
        chk("R5 sticky", 32'(irq), 32'hC);

        // R5: set and clear in the same cycle, set wins on bit 1.
        wr(8'h00, 32'h0000_000A, 4'h2);
        m_state = (m_state & ~4'hA) | 4'h2;
        chk("R5 set wins irq", 32'(irq), 32'(m_state & m_en));
        rd(8'h00, 32'(m_state), "R5 set wins state");

        // R6: control masking.
        wr(8'h0C, 32'hFFFF_FFFF);
        chk("R6 cfg_ctrl mask", cfg_ctrl, 32'hFFFF_03F7);
        rd(8'h0C, 32'hFFFF_03F7, "R6 ctrl readback");
        wr(8'h0C, 32'h1234_0881);
        chk("R6 cfg_ctrl value", cfg_ctrl, 32'h1234_0081);

        // R7: status packing; write ignored.
        st_flags = 5'b10101;
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0000_0025, "R7 status");
        chk("R7 ctrl untouched", cfg_ctrl, 32'h1234_0081);
        st_flags = 5'b01010;
        rd(8'h10, 32'h0000_0012, "R7 status second");

        // R8: receive data read and pop strobe.
        rx_byte = 8'hA5;
        rd(8'h14, 32'h0000_00A5, "R8 rx data");
        chk("R8 rx_pop", 32'(rx_pop), 1);
        @(negedge clk);
        chk("R8 rx_pop drops", 32'(rx_pop), 0);
        wr(8'h14, 32'h0000_0077);
        chk("R8 write ignored", 32'({rx_pop, tx_push}), 0);
        rd(8'h14, 32'h0000_00A5, "R8 rx data after write");

        // R9: transmit push.
        wr(8'h18, 32'h0000_01C3);
        chk("R9 tx_push", 32'(tx_push), 1);
        chk("R9 tx_byte", 32'(tx_byte), 32'hC3);
        @(negedge clk);
        chk("R9 tx_push drops", 32'(tx_push), 0);
        rd(8'h18, 0, "R9 txd reads zero");

        // R10: FIFO control fields and flush strobes.
        wr(8'h1C, 32'h0000_007F);
        chk("R10 flush both", 32'({rx_flush, tx_flush}), 32'h3);
        chk("R10 levels", 32'({tx_lvl, rx_lvl}), 32'h1F);
        @(negedge clk);
        chk("R10 flush drops", 32'({rx_flush, tx_flush}), 0);
        rd(8'h1C, 32'h0000_007C, "R10 fctl readback");
        wr(8'h1C, 32'h0000_0021);
        chk("R10 rx flush only", 32'({rx_flush, tx_flush}), 32'h2);
        chk("R10 levels second", 32'({tx_lvl, rx_lvl}), 32'h08);

        // R11: unmapped and misaligned accesses.
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, 0, "R11 unmapped read");
        rd(8'h3C, 0, "R11 high unmapped read");
        wr(8'h05, 32'h0000_0000);
        chk("R11 misaligned write", 32'(irq), 32'(m_state & m_en));
        rd(8'h04, 32'h0000_000F, "R11 enable kept");
        rd(8'h01, 0, "R11 misaligned read");

        // R12: back-to-back reads each get one valid word.
        reg_rd = 1'b1; reg_addr = ADDR_W'(8'h04);
        begin
            rd_item_t it;
            it.exp = 32'hF; it.tag = "R12 back-to-back a";
            exp_q.push_back(it);
            it.tag = "R12 back-to-back b";
            exp_q.push_back(it);
        end
        repeat (2) @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12 queue drained", 32'(exp_q.size()), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule